// File: doc/BRIEF.md
# Region Cache Maintenance Engine

This block sits beside a system-level cache and carries out maintenance over an address range. Software programs the range and the operation through a small register port and then polls a busy flag. The engine walks the range one cache line at a time. For each line it raises a request toward the cache tag/data logic, carrying the line address and one of three operation codes: write back, invalidate, or write back then invalidate.

Software writes the range end first. Writing the range start then launches the walk, and only when the engine is idle. The line holding the end address is exclusive, so a caller covers a buffer of `size` bytes at `base` by writing `base + size + line_bytes - 1` as the end. Address bits below the line size are dropped in both range registers. The operation comes from two control fields taken together, and it is captured at launch. Line size and capacity code are fixed by parameters and can be read from a configuration register.

The walker has two states. `ST_IDLE`: no request is pending and busy reads 0. `ST_ISSUE`: a request is presented and busy reads 1. Its transitions are:
- T_LAUNCH (`ST_IDLE` to `ST_ISSUE`): a start write with start line below end line.
- T_EMPTY (stay in `ST_IDLE`): a start write with an empty range.
- T_STEP (stay in `ST_ISSUE`, next line): a handshake on a line that is not the last.
- T_FINISH (`ST_ISSUE` to `ST_IDLE`): a handshake on the last line.

Top module: `region_maint_engine`

## Requirements
- R1: After reset, the control, range-start and range-end registers read 0 and `req_valid` is 0.
- R2: The configuration register at 0x901 reads the line-size bit at bit 4 (0 = 128-byte lines, 1 = 64-byte lines) and the 3-bit capacity code at bits 2:0. All other bits read 0.
- R3: The operation code on `req_op` is 01 (write back) when control bits 11:9 differ from 001. It is 10 (invalidate) when those bits are 001 and bit 6 is 0, and 11 (write back then invalidate) when they are 001 and bit 6 is 1.
- R4: A write to the range-start register (0x914) while idle, with a non-empty range, makes control bit 8 (busy) read 1 from the next cycle. The first request carries the start line's address.
- R5: The engine requests each line from the start line up to, but not including, the line holding the range-end (0x916) address. It makes exactly one request per line, in ascending order, with addresses one line apart.
- R6: A request holds its address and operation steady until `req_ready` is seen high.
- R7: Busy reads 0 in the cycle after the handshake of the last line. With `req_ready` held high, an N-line walk reads busy for exactly N cycles.
- R8: If the end line is not above the start line, a start write issues no request and busy never reads 1.
- R9: Address bits below the line size are ignored. Both range registers read back line-aligned, and the walk uses line indices only.
- R10: While busy, writes to the range registers, to the control bits 6 and 11:9, and to the start trigger have no effect. The operation of a walk in progress never changes. Bit 0 stays writable.
- R11: The control register at 0x903 holds a read/write disable bit at bit 0, the mode bit at bit 6, and the operation field at bits 11:9. Bit 8 is busy and read-only. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | RA_W | Register address, used for reads and writes |
| reg_wdata | input | DW | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| req_valid | output | 1 | A line maintenance request is presented |
| req_ready | input | 1 | The cache accepts the request |
| req_addr | output | AW | Line-aligned address of the request |
| req_op | output | 2 | Operation code: 01 write back, 10 invalidate, 11 both |

## Verification
Read data is combinational, so a register written at a clock edge is read back before the next edge. The launch edge that takes a start write also sets busy, so busy is due in the first half-cycle after that write. Request handshakes happen at the edge where `req_valid` and `req_ready` are both high. The bench sets `req_ready` and records each handshake at the falling edge before that edge, and it counts busy cycles by polling at falling edges. A walk of N lines with ready held high must therefore show busy for exactly N polls.

// File: rtl/rme_pkg.sv
package rme_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WB    = 2'b01,
        OP_INV   = 2'b10,
        OP_WBINV = 2'b11
    } maint_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } walk_st_e;

    localparam logic [11:0] RA_CFG    = 12'h901;
    localparam logic [11:0] RA_CTRL   = 12'h903;
    localparam logic [11:0] RA_RSTART = 12'h914;
    localparam logic [11:0] RA_REND   = 12'h916;

    localparam int CB_DIS   = 0;
    localparam int CB_MODE  = 6;
    localparam int CB_BUSY  = 8;
    localparam int CB_OPLO  = 9;
    localparam int CFGB_LSZ = 4;

    typedef struct packed {
        logic [2:0] rop;
        logic       mode;
        logic       dis;
    } ctrl_t;

endpackage

// File: rtl/rme_regs.sv
module rme_regs
    import rme_pkg::*;
#(
    parameter int RA_W          = 12,
    parameter int DW            = 32,
    parameter int AW            = 32,
    parameter int LSH           = 7,
    parameter int CFG_LINE_64   = 0,
    parameter int CFG_SIZE_CODE = 2,
    localparam int LIW          = AW - LSH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            reg_we,
    input  logic            busy,
    output logic [DW-1:0]   reg_rdata,
    output ctrl_t           ctrl_q,
    output logic [LIW-1:0]  end_line,
    output logic            launch,
    output logic [LIW-1:0]  launch_line
);

    logic [LIW-1:0] start_q;
    logic [LIW-1:0] end_q;
    logic           wr_ctrl, wr_start, wr_end;
    logic           unused_wlow;

    assign unused_wlow = &{1'b0, reg_wdata[LSH-1:0]};

    assign wr_ctrl  = reg_we && (reg_addr == RA_W'(RA_CTRL));
    assign wr_start = reg_we && (reg_addr == RA_W'(RA_RSTART));
    assign wr_end   = reg_we && (reg_addr == RA_W'(RA_REND));

    assign launch      = wr_start && !busy;
    assign launch_line = reg_wdata[AW-1:LSH];
    assign end_line    = end_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.dis <= reg_wdata[CB_DIS];
                if (!busy) begin
                    ctrl_q.mode <= reg_wdata[CB_MODE];
                    ctrl_q.rop  <= reg_wdata[CB_OPLO+2:CB_OPLO];
                end
            end
            if (launch) begin
                start_q <= reg_wdata[AW-1:LSH];
            end
            if (wr_end && !busy) begin
                end_q <= reg_wdata[AW-1:LSH];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_W'(RA_CFG): begin
                reg_rdata[CFGB_LSZ] = (CFG_LINE_64 != 0);
                reg_rdata[2:0]      = 3'(CFG_SIZE_CODE);
            end
            RA_W'(RA_CTRL): begin
                reg_rdata[CB_DIS]              = ctrl_q.dis;
                reg_rdata[CB_MODE]             = ctrl_q.mode;
                reg_rdata[CB_BUSY]             = busy;
                reg_rdata[CB_OPLO+2:CB_OPLO]   = ctrl_q.rop;
            end
            RA_W'(RA_RSTART): reg_rdata = DW'({start_q, {LSH{1'b0}}});
            RA_W'(RA_REND):   reg_rdata = DW'({end_q, {LSH{1'b0}}});
            default:          reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rme_opsel.sv
module rme_opsel
    import rme_pkg::*;
(
    input  ctrl_t     ctrl,
    output maint_op_e op
);

    always_comb begin
        if (ctrl.rop == 3'b001) begin
            op = ctrl.mode ? OP_WBINV : OP_INV;
        end else begin
            op = OP_WB;
        end
    end

endmodule

// File: rtl/rme_walker.sv
module rme_walker
    import rme_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LSH  = 7,
    localparam int LIW = AW - LSH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic [LIW-1:0] launch_line,
    input  logic [LIW-1:0] end_line,
    input  maint_op_e      op_in,
    input  logic           req_ready,
    output logic           req_valid,
    output logic [AW-1:0]  req_addr,
    output logic [1:0]     req_op,
    output logic           busy
);

    walk_st_e       state_q, state_d;
    logic [LIW-1:0] cur_q, stop_q;
    maint_op_e      op_q;
    logic           nonempty, last_line, take;

    assign nonempty  = launch && (launch_line < end_line);
    assign last_line = ((cur_q + LIW'(1)) == stop_q);
    assign take      = (state_q == ST_ISSUE) && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (nonempty) state_d = ST_ISSUE;
            ST_ISSUE: if (take && last_line) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            stop_q <= '0;
            op_q   <= OP_NONE;
        end else if (state_q == ST_IDLE) begin
            if (nonempty) begin
                cur_q  <= launch_line;
                stop_q <= end_line;
                op_q   <= op_in;
            end
        end else if (take && !last_line) begin
            cur_q <= cur_q + LIW'(1);
        end
    end

    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        busy      = (state_q == ST_ISSUE);
        req_addr  = {cur_q, {LSH{1'b0}}};
        req_op    = op_q;
    end

endmodule

// File: rtl/region_maint_engine.sv
module region_maint_engine
    import rme_pkg::*;
#(
    parameter int RA_W          = 12,
    parameter int DW            = 32,
    parameter int AW            = 32,
    parameter int CFG_LINE_64   = 0,
    parameter int CFG_SIZE_CODE = 2,
    localparam int LSH          = (CFG_LINE_64 != 0) ? 6 : 7,
    localparam int LIW          = AW - LSH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            reg_we,
    output logic [DW-1:0]   reg_rdata,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [AW-1:0]   req_addr,
    output logic [1:0]      req_op
);

    ctrl_t          w_ctrl;
    logic [LIW-1:0] w_end_line, w_launch_line;
    logic           w_launch, w_busy;
    maint_op_e      w_op;

    rme_regs #(
        .RA_W(RA_W), .DW(DW), .AW(AW), .LSH(LSH),
        .CFG_LINE_64(CFG_LINE_64), .CFG_SIZE_CODE(CFG_SIZE_CODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .busy(w_busy), .reg_rdata(reg_rdata), .ctrl_q(w_ctrl),
        .end_line(w_end_line), .launch(w_launch), .launch_line(w_launch_line)
    );

    rme_opsel u_opsel (
        .ctrl(w_ctrl), .op(w_op)
    );

    rme_walker #(.AW(AW), .LSH(LSH)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .launch(w_launch), .launch_line(w_launch_line), .end_line(w_end_line),
        .op_in(w_op), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
        .busy(w_busy)
    );

endmodule

// File: rtl/rme_chk.sv
module rme_chk #(
    parameter int AW  = 32,
    parameter int LSH = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_op,
    input logic          busy
);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_op));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid || (req_addr == $past(req_addr) + AW'(1 << LSH)));

    p_op_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid || $stable(req_op));

    p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[LSH-1:0] == '0);

    p_clear_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(req_valid && req_ready));

    p_opcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_op != 2'b00);

endmodule

bind region_maint_engine rme_chk #(.AW(AW), .LSH(LSH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .busy(w_busy)
);

// File: tb/sim_region_maint_engine.sv
module sim_region_maint_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CFG = 12'h901, A_CTRL = 12'h903, A_START = 12'h914, A_END = 12'h916;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [1:0]  req_op;

    int tests = 0;
    int fails = 0;
    int ready_mode = 0;
    int cyc = 0;
    int log_n = 0;
    logic [31:0] log_addr [64];
    logic [1:0]  log_op [64];
    bit done = 0;

    region_maint_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_op(req_op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // cache model: choose ready, then record the handshake due at the next rising edge
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0:       req_ready = 1'b1;
            1:       req_ready = (cyc % 3) != 0;
            default: req_ready = 1'b0;
        endcase
        if (req_valid && req_ready && log_n < 64) begin
            log_addr[log_n] = req_addr;
            log_op[log_n]   = req_op;
            log_n++;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int cnt);
        logic [31:0] v;
        cnt = 0;
        for (int k = 0; k < 2000; k++) begin
            rd(A_CTRL, v);
            if (!v[8]) break;
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_region(input string req, input logic [31:0] s, input logic [31:0] e,
                              input logic [31:0] first, input int n, input logic [1:0] op,
                              input int mode);
        int cnt;
        ready_mode = mode;
        log_n = 0;
        wr(A_END, e);
        wr(A_START, s);
        wait_idle(cnt);
        chk(req, "request count", 32'(log_n), 32'(n));
        for (int i = 0; i < n && i < log_n; i++) begin
            chk(req, "line address", log_addr[i], first + 32'(i * 128));
            chk(req, "operation", 32'(log_op[i]), 32'(op));
        end
        if (mode == 0) chk("R7", "busy cycles", 32'(cnt), 32'(n));
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v);  chk("R1", "control", v, 32'h0);
        rd(A_START, v); chk("R1", "start", v, 32'h0);
        rd(A_END, v);   chk("R1", "end", v, 32'h0);
        chk("R1", "req_valid", 32'(req_valid), 32'h0);
    endtask

    task automatic t_config;
        logic [31:0] v;
        rd(A_CFG, v); chk("R2", "config", v, 32'h0000_0002);
    endtask

    task automatic t_flush;
        logic [31:0] v;
        wr(A_CTRL, 32'h0);
        ready_mode = 0;
        log_n = 0;
        wr(A_END, 32'h0000_127F);
        wr(A_START, 32'h0000_1000);
        rd(A_CTRL, v); chk("R4", "busy after start", 32'(v[8]), 32'h1);
        chk("R4", "first request valid", 32'(req_valid), 32'h1);
        chk("R4", "first request address", req_addr, 32'h1000);
        repeat (6) @(negedge clk);
        run_region("R5", 32'h0000_1000, 32'h0000_127F, 32'h1000, 4, 2'b01, 0);
    endtask

    task automatic t_invalidate_stall;
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_0200);
        // R6: ready toggles, each line must still appear once in order
        run_region("R3", 32'h0000_2345, 32'h0000_24C4, 32'h2300, 3, 2'b10, 1);
        rd(A_START, v); chk("R9", "aligned start", v, 32'h2300);
        rd(A_END, v);   chk("R9", "aligned end", v, 32'h2480);
    endtask

    task automatic t_flush_inv;
        wr(A_CTRL, 32'h0000_0240);
        run_region("R3", 32'h0000_3000, 32'h0000_30FF, 32'h3000, 1, 2'b11, 0);
    endtask

    task automatic t_other_field;
        wr(A_CTRL, 32'h0000_0600);
        run_region("R3", 32'h0000_4000, 32'h0000_417F, 32'h4000, 2, 2'b01, 1);
    endtask

    task automatic t_empty;
        wr(A_CTRL, 32'h0);
        run_region("R8", 32'h0000_5010, 32'h0000_5040, 32'h0, 0, 2'b01, 0);
        run_region("R8", 32'h0000_5000, 32'h0000_4000, 32'h0, 0, 2'b01, 0);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        int cnt;
        wr(A_CTRL, 32'h0);
        ready_mode = 2;
        log_n = 0;
        wr(A_END, 32'h0000_8100);
        wr(A_START, 32'h0000_8000);
        wr(A_END, 32'h0000_9000);
        wr(A_CTRL, 32'h0000_0E41);
        wr(A_START, 32'h0000_A000);
        rd(A_CTRL, v); chk("R10", "control while busy", v, 32'h0000_0101);
        rd(A_END, v);  chk("R10", "end while busy", v, 32'h8100);
        rd(A_START, v); chk("R10", "start while busy", v, 32'h8000);
        ready_mode = 0;
        wait_idle(cnt);
        chk("R10", "request count", 32'(log_n), 32'h2);
        chk("R10", "line 0", log_addr[0], 32'h8000);
        chk("R10", "line 1", log_addr[1], 32'h8080);
        chk("R10", "op 0", 32'(log_op[0]), 32'h1);
        chk("R10", "op 1", 32'(log_op[1]), 32'h1);
        rd(A_CTRL, v); chk("R10", "control after run", v, 32'h0000_0001);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_ctrl_layout;
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R11", "control mask", v, 32'h0000_0E41);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R11", "control cleared", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_flush;
        t_invalidate_stall;
        t_flush_inv;
        t_other_field;
        t_empty;
        t_busy_ignore;
        t_ctrl_layout;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule